// File: doc/BRIEF.md
# Serial Synthesizer Configuration Loader

This block receives divider settings for a clock synthesizer over a three-wire serial port: a serial clock, a data line and a load strobe. All three inputs are asynchronous to the system clock. They pass through a common synchronizer, so the data line stays aligned with the serial clock. Each rising serial-clock edge shifts one data bit into an 18-bit shift register. Shifting runs whether or not the load strobe is high.

A rising edge on the load strobe checks the most recent 18 bits. If the output-divider code names a real ratio, the three fields (input prescaler, output-divider code, feedback divider) are copied into the active registers in a single system-clock cycle, and an update pulse is raised. If the code is invalid, the active settings are left as they were and an error pulse is raised instead. The block also decodes the active output-divider code into a one-hot divide ratio for the divider logic downstream.

Top module: `synth_cfg_loader`

## Requirements
- R1: A frame is 18 bits, sent most significant first: the prescaler bits 4..0, then the output-divider code bits 2..0, then the feedback bits 9..0. In the captured word, the prescaler sits at [17:13], the code at [12:10] and the feedback value at [9:0].
- R2: Data is sampled on rising serial-clock edges only. Bits keep shifting while the load strobe is high.
- R3: When more than 18 bits are shifted before a load, the oldest bits drop out and the last 18 form the frame.
- R4: A rising load edge with a valid code updates all three active fields in the same cycle. `cfg_upd_o` is then high for exactly one cycle.
- R5: Output-divider codes 000, 110 and 111 are invalid. A load with such a code leaves every active field unchanged and raises `cfg_err_o` for exactly one cycle. `cfg_err_o` and `cfg_upd_o` are never high together.
- R6: After reset the active prescaler is 11011, the output-divider code is 010 and the feedback value is 1001000000. No pulse is raised during reset.
- R7: `odiv_ratio_o` is one-hot and equals 2 to the power of the active code (codes 001..101 give ratios 2..32).
- R8: A load strobe that is held high does not commit again. Only its next rising edge does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock, asynchronous |
| sdata_i | input | 1 | Serial data, asynchronous |
| sload_i | input | 1 | Load strobe, asynchronous |
| presc_o | output | 5 | Active input prescaler value |
| odiv_code_o | output | 3 | Active output-divider code |
| fbdiv_o | output | 10 | Active feedback divider value |
| odiv_ratio_o | output | 6 | One-hot output divide ratio |
| cfg_upd_o | output | 1 | One-cycle pulse on a successful commit |
| cfg_err_o | output | 1 | One-cycle pulse on a rejected frame |

## Verification
The bench builds the block with the default field widths and raises the synchronizer depth to three stages. The deeper synchronizer lengthens the path from the serial pins, which tests that data and clock stay aligned through the extra delay. The default widths keep the real frame length, so overlong frames, all three invalid codes and the extreme ratios 2 and 32 can all be driven. Pulse widths are measured by counting high samples of the update and error outputs across each load.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;
  localparam int PRESC_W = 5;
  localparam int CODE_W  = 3;
  localparam int FB_W    = 10;
  localparam int CODE_MIN = 1;
  localparam int CODE_MAX = 5;
  localparam logic [PRESC_W-1:0] PRESC_RST = 5'b11011;
  localparam logic [CODE_W-1:0]  CODE_RST  = 3'b010;
  localparam logic [FB_W-1:0]    FB_RST    = 10'b1001000000;
endpackage

// File: rtl/synth_cfg_sync.sv
module synth_cfg_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) stg_q[s] <= '0;
          else         stg_q[s] <= d_i;
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) stg_q[s] <= '0;
          else         stg_q[s] <= stg_q[s-1];
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/synth_cfg_shreg.sv
module synth_cfg_shreg #(
  parameter int W = 18
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [W-1:0] word_o
);
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)      word_o <= '0;
    else if (shift_i) word_o <= {word_o[W-2:0], bit_i};
endmodule

// File: rtl/synth_cfg_commit.sv
module synth_cfg_commit
  import synth_cfg_pkg::*;
#(
  parameter int P_W   = PRESC_W,
  parameter int N_W   = CODE_W,
  parameter int M_W   = FB_W,
  parameter int N_MIN = CODE_MIN,
  parameter int N_MAX = CODE_MAX,
  parameter logic [P_W-1:0] P_RST = PRESC_RST,
  parameter logic [N_W-1:0] N_RST = CODE_RST,
  parameter logic [M_W-1:0] M_RST = FB_RST,
  localparam int FRAME_W = P_W + N_W + M_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] word_i,
  output logic [P_W-1:0]     presc_o,
  output logic [N_W-1:0]     code_o,
  output logic [M_W-1:0]     fb_o,
  output logic               upd_o,
  output logic               err_o
);
  localparam logic [N_W-1:0] LO_C = N_W'(N_MIN);
  localparam logic [N_W-1:0] HI_C = N_W'(N_MAX);

  // first bit on the wire lands at the MSB end
  logic [P_W-1:0] w_p;
  logic [N_W-1:0] w_n;
  logic [M_W-1:0] w_m;
  logic           code_ok;

  assign w_p     = word_i[FRAME_W-1 -: P_W];
  assign w_n     = word_i[M_W +: N_W];
  assign w_m     = word_i[M_W-1:0];
  assign code_ok = (w_n >= LO_C) && (w_n <= HI_C);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      presc_o <= P_RST;
      code_o  <= N_RST;
      fb_o    <= M_RST;
      upd_o   <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      upd_o <= load_i && code_ok;
      err_o <= load_i && !code_ok;
      if (load_i && code_ok) begin
        presc_o <= w_p;
        code_o  <= w_n;
        fb_o    <= w_m;
      end
    end
endmodule

// File: rtl/synth_cfg_odiv_dec.sv
module synth_cfg_odiv_dec #(
  parameter int N_W     = 3,
  parameter int RATIO_W = 6
) (
  input  logic [N_W-1:0]     code_i,
  output logic [RATIO_W-1:0] ratio_o
);
  always_comb begin
    ratio_o = '0;
    for (int k = 0; k < RATIO_W; k++)
      if (code_i == N_W'(k)) ratio_o[k] = 1'b1;
  end
endmodule

// File: rtl/synth_cfg_loader.sv
module synth_cfg_loader
  import synth_cfg_pkg::*;
#(
  parameter int P_W         = PRESC_W,
  parameter int N_W         = CODE_W,
  parameter int M_W         = FB_W,
  parameter int N_MIN       = CODE_MIN,
  parameter int N_MAX       = CODE_MAX,
  parameter int SYNC_STAGES = 2,
  localparam int FRAME_W = P_W + N_W + M_W,
  localparam int RATIO_W = N_MAX + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sclk_i,
  input  logic               sdata_i,
  input  logic               sload_i,
  output logic [P_W-1:0]     presc_o,
  output logic [N_W-1:0]     odiv_code_o,
  output logic [M_W-1:0]     fbdiv_o,
  output logic [RATIO_W-1:0] odiv_ratio_o,
  output logic               cfg_upd_o,
  output logic               cfg_err_o
);
  logic [2:0]         pins_s;
  logic [1:0]         ctl_d;
  logic               sclk_rise, load_rise;
  logic [FRAME_W-1:0] word;

  // one synchronizer for all three pins keeps data aligned to its clock
  synth_cfg_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sload_i, sclk_i, sdata_i}),
    .q_o   (pins_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) ctl_d <= '0;
    else         ctl_d <= pins_s[2:1];

  assign sclk_rise = pins_s[1] & ~ctl_d[0];
  assign load_rise = pins_s[2] & ~ctl_d[1];

  synth_cfg_shreg #(.W(FRAME_W)) u_shreg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .shift_i(sclk_rise),
    .bit_i  (pins_s[0]),
    .word_o (word)
  );

  synth_cfg_commit #(
    .P_W(P_W), .N_W(N_W), .M_W(M_W), .N_MIN(N_MIN), .N_MAX(N_MAX)
  ) u_commit (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_rise),
    .word_i (word),
    .presc_o(presc_o),
    .code_o (odiv_code_o),
    .fb_o   (fbdiv_o),
    .upd_o  (cfg_upd_o),
    .err_o  (cfg_err_o)
  );

  synth_cfg_odiv_dec #(.N_W(N_W), .RATIO_W(RATIO_W)) u_dec (
    .code_i (odiv_code_o),
    .ratio_o(odiv_ratio_o)
  );
endmodule

// File: rtl/synth_cfg_loader_chk.sv
module synth_cfg_loader_chk #(
  parameter int P_W     = 5,
  parameter int N_W     = 3,
  parameter int M_W     = 10,
  parameter int N_MIN   = 1,
  parameter int N_MAX   = 5,
  parameter int RATIO_W = 6
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [P_W-1:0]     presc_o,
  input logic [N_W-1:0]     odiv_code_o,
  input logic [M_W-1:0]     fbdiv_o,
  input logic [RATIO_W-1:0] odiv_ratio_o,
  input logic               cfg_upd_o,
  input logic               cfg_err_o
);
  localparam logic [N_W-1:0] LO_C = N_W'(N_MIN);
  localparam logic [N_W-1:0] HI_C = N_W'(N_MAX);

  assert_hold_no_upd_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_upd_o |-> ($stable(presc_o) && $stable(odiv_code_o) && $stable(fbdiv_o)));

  assert_upd_one_cycle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_upd_o |=> !cfg_upd_o);

  assert_err_keeps_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> ($stable(presc_o) && $stable(odiv_code_o) && $stable(fbdiv_o)));

  assert_err_one_cycle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |=> !cfg_err_o);

  assert_no_both_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cfg_err_o && cfg_upd_o));

  assert_code_valid_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (odiv_code_o >= LO_C) && (odiv_code_o <= HI_C));

  assert_ratio_onehot_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(odiv_ratio_o) == 1 && !odiv_ratio_o[0]);
endmodule

bind synth_cfg_loader synth_cfg_loader_chk #(
  .P_W(P_W), .N_W(N_W), .M_W(M_W), .N_MIN(N_MIN), .N_MAX(N_MAX), .RATIO_W(RATIO_W)
) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .presc_o     (presc_o),
  .odiv_code_o (odiv_code_o),
  .fbdiv_o     (fbdiv_o),
  .odiv_ratio_o(odiv_ratio_o),
  .cfg_upd_o   (cfg_upd_o),
  .cfg_err_o   (cfg_err_o)
);

// File: tb/synth_cfg_loader_tb.sv
module synth_cfg_loader_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 9;
  // frame = {prescaler[4:0], code[2:0], feedback[9:0]}
  localparam logic [17:0] VEC [NVEC] = '{
    {5'b11001, 3'b010, 10'b1001000000},
    {5'b11011, 3'b100, 10'b1000000000},
    {5'b11011, 3'b101, 10'b0110101001},
    {5'b10101, 3'b000, 10'b1111111111},
    {5'b11011, 3'b001, 10'b1101010010},
    {5'b00000, 3'b110, 10'b0000000001},
    {5'b11011, 3'b011, 10'b1001110001},
    {5'b11111, 3'b111, 10'b1010101010},
    {5'b00001, 3'b101, 10'b0000000000}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, sdata = 1'b0, sload = 1'b0;
  logic [4:0] presc;
  logic [2:0] code;
  logic [9:0] fb;
  logic [5:0] ratio;
  logic upd, err;
  int n_tests = 0, n_fail = 0, upd_cnt = 0, err_cnt = 0;
  logic [17:0] exp_w;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  synth_cfg_loader #(.SYNC_STAGES(3)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .sdata_i(sdata), .sload_i(sload),
    .presc_o(presc), .odiv_code_o(code), .fbdiv_o(fb), .odiv_ratio_o(ratio),
    .cfg_upd_o(upd), .cfg_err_o(err)
  );

  always @(negedge clk) begin
    if (upd) upd_cnt++;
    if (err) err_cnt++;
  end

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] expv);
    n_tests++;
    if (got !== expv) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, expv);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [31:0] bits, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdata = bits[i];
      wait_clk(2);
      sclk = 1'b1;
      wait_clk(3);
      sclk = 1'b0;
      wait_clk(3);
    end
  endtask

  task automatic pulse_load();
    sload = 1'b1;
    wait_clk(8);
    sload = 1'b0;
    wait_clk(4);
  endtask

  task automatic check_active(input string req, input logic [17:0] w);
    check(req, {27'd0, presc}, {27'd0, w[17:13]});
    check(req, {29'd0, code}, {29'd0, w[12:10]});
    check(req, {22'd0, fb}, {22'd0, w[9:0]});
    check(req, {26'd0, ratio}, 32'd1 << w[12:10]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    wait_clk(3);
    // R6 defaults while in reset and right after release
    exp_w = {5'b11011, 3'b010, 10'b1001000000};
    check_active("R6 in reset", exp_w);
    check("R6 no pulse", {30'd0, upd, err}, 32'd0);
    rst_n = 1'b1;
    wait_clk(3);
    check_active("R6 after reset", exp_w);

    // R1 R4 R5 R7 table walk
    for (int v = 0; v < NVEC; v++) begin
      int u0, e0;
      logic ok;
      ok = (VEC[v][12:10] >= 3'd1) && (VEC[v][12:10] <= 3'd5);
      send_bits({14'd0, VEC[v]}, 18);
      u0 = upd_cnt;
      e0 = err_cnt;
      pulse_load();
      if (ok) exp_w = VEC[v];
      check_active(ok ? "R1 R4 R7 commit" : "R5 reject keeps", exp_w);
      check(ok ? "R4 upd pulse" : "R5 err pulse", upd_cnt - u0, ok ? 32'd1 : 32'd0);
      check(ok ? "R4 no err" : "R5 err pulse", err_cnt - e0, ok ? 32'd0 : 32'd1);
    end

    // R3 overlong: 7 leading junk bits, then a frame
    send_bits(32'h5B, 7);
    send_bits({14'd0, 5'b10011, 3'b011, 10'b0011001100}, 18);
    pulse_load();
    exp_w = {5'b10011, 3'b011, 10'b0011001100};
    check_active("R3 last 18 bits", exp_w);

    // R2 R8: hold load high, shift a new frame, no second commit
    begin
      int u0;
      u0 = upd_cnt;
      sload = 1'b1;
      wait_clk(8);
      check("R8 rise with old word", upd_cnt - u0, 32'd1);
      send_bits({14'd0, 5'b01110, 3'b001, 10'b1110001110}, 18);
      check_active("R8 held load no commit", exp_w);
      check("R8 single upd", upd_cnt - u0, 32'd1);
      sload = 1'b0;
      wait_clk(4);
      pulse_load();
      exp_w = {5'b01110, 3'b001, 10'b1110001110};
      check_active("R2 shifted while load high", exp_w);
      check("R8 second rise commits", upd_cnt - u0, 32'd2);
    end

    // R2: level changes of data without sclk edges do not shift
    sdata = 1'b1;
    wait_clk(10);
    sdata = 1'b0;
    wait_clk(10);
    pulse_load();
    check_active("R2 no shift without edge", exp_w);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule